// File: doc/BRIEF.md
# Tiled Pixel-to-SDRAM Address Mapper

This block converts image pixel coordinates into SDRAM bank, row and column addresses. Each SDRAM row holds one 64-pixel-wide by 32-pixel-tall tile of the picture. Pixels are 8 bits wide, so four horizontally neighbouring pixels share one 32-bit column, and a tile fills the 512 columns of one row. Tiles are assigned banks in a checkerboard of 2x2 groups. As a result, two tiles that touch left/right or above/below never share a bank.

The block has two independent request paths. The point path takes one (x, y) coordinate and returns its bank, row and column. The span path takes a rectangle given by its start corner, width and height, and returns the list of distinct bank/row pairs it touches. The list holds 1, 2 or 4 pairs in tile raster order, together with a count. A downstream command sequencer uses this list to open every needed row before it transfers data. Both paths register their inputs into outputs with one cycle of latency. Command timing and the data path are handled by other blocks.

Top module: `sdram_tile_mapper`

## Requirements
- R1: `pt_out_valid` is high in exactly the cycle after a cycle with `pt_valid` high. Reset (asynchronous, `rst_n` low) clears every output to zero.
- R2: The point column is (y mod 32)*16 + floor((x mod 64)/4). It is 9 bits wide, with the y offset in bits 8:4 and the x word index in bits 3:0.
- R3: The point bank is 2*(ty mod 2) + (tx mod 2), where tx = floor(x/64) and ty = floor(y/32).
- R4: The point row is floor(ty/2)*ceil(TILES_X/2) + floor(tx/2), where TILES_X = FRAME_W/64.
- R5: A rectangle (width 1..64, height 1..32, lying inside the frame) reports a count of 1 when it stays inside one tile. The count is 2 when it crosses exactly one vertical or one horizontal tile edge, and 4 when it crosses both. The reported banks are pairwise distinct.
- R6: Slot i of the report uses bits `rs_bank[2i+1:2i]` and `rs_row[12i+11:12i]`. Slot 0 is the tile holding the start corner. The remaining slots follow tile raster order (right neighbour before lower neighbour). Each pair is computed as in R3 and R4. Slots at or above the count are zero.
- R7: `rs_valid` is high in exactly the cycle after a cycle with `rq_valid` high. While `rq_valid` is low, the span outputs keep their values.
- R8: While `pt_valid` is low, `pt_bank`, `pt_row` and `pt_col` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pt_valid | input | 1 | Point coordinate present |
| pt_x | input | X_W (11) | Pixel column |
| pt_y | input | Y_W (11) | Pixel line |
| pt_out_valid | output | 1 | Point address present |
| pt_bank | output | 2 | Bank of the point |
| pt_row | output | 12 | Row of the point |
| pt_col | output | 9 | 32-bit column of the point |
| rq_valid | input | 1 | Rectangle request present |
| rq_x | input | X_W (11) | Rectangle start column |
| rq_y | input | Y_W (11) | Rectangle start line |
| rq_w | input | SZ_W (7) | Rectangle width in pixels |
| rq_h | input | SZ_W (7) | Rectangle height in pixels |
| rs_valid | output | 1 | Span report present |
| rs_count | output | 3 | Number of bank/row pairs (1, 2 or 4) |
| rs_bank | output | 8 | Four 2-bit bank slots |
| rs_row | output | 48 | Four 12-bit row slots |

## Verification
The bound checker verifies several properties on every cycle. It checks the one-cycle valid latency of both paths and that the addresses hold while no request is present. It checks that the bank of a point and of span slot 0 follows the tile parity of the registered coordinate. It also checks that the span count is legal, that it equals the number of distinct banks listed, and that empty slots are zero. The exact column and row arithmetic, the raster ordering of the slots, and corner cases only show up in the bench scenarios. Those corner cases include rectangles that end exactly on a tile edge, one-pixel spans straddling an edge, and the last tile of the frame. The bench scenarios compare against independently computed values.

// File: rtl/sdram_tile_pkg.sv
package sdram_tile_pkg;
  localparam int TILE_W_LOG = 6;
  localparam int TILE_H_LOG = 5;
  localparam int WORD_PIX_LOG = 2;
  localparam int COL_W = (TILE_W_LOG - WORD_PIX_LOG) + TILE_H_LOG;
  localparam int BANK_W = 2;
  localparam int ROW_W = 12;
  localparam int NSLOT = 4;
  localparam int CNT_W = 3;

  // Column inside a tile: line offset is the upper field, word index the lower.
  function automatic logic [COL_W-1:0] pix_col(input logic [TILE_H_LOG-1:0] y_off,
                                               input logic [TILE_W_LOG-1:0] x_off);
    return {y_off, x_off[TILE_W_LOG-1:WORD_PIX_LOG]};
  endfunction

  // Checkerboard over 2x2 tile groups: tile line parity is the high bank bit.
  function automatic logic [BANK_W-1:0] tile_bank(input logic tx_lsb, input logic ty_lsb);
    return {ty_lsb, tx_lsb};
  endfunction

  // One row per 2x2 group, groups numbered in raster order.
  function automatic logic [ROW_W-1:0] tile_row(input logic [15:0] tx,
                                                input logic [15:0] ty,
                                                input logic [15:0] half_tx);
    return ROW_W'((32'(ty >> 1) * 32'(half_tx)) + 32'(tx >> 1));
  endfunction

  // Count of pairs from the two edge-crossing flags.
  function automatic logic [CNT_W-1:0] span_count(input logic cx, input logic cy);
    return (cx && cy) ? CNT_W'(4) : ((cx || cy) ? CNT_W'(2) : CNT_W'(1));
  endfunction
endpackage

// File: rtl/pix_addr_decode.sv
module pix_addr_decode
  import sdram_tile_pkg::*;
#(
  parameter int X_W = 11,
  parameter int Y_W = 11,
  parameter int HALF_TX = 15
) (
  input  logic [X_W-1:0]    x,
  input  logic [Y_W-1:0]    y,
  output logic [BANK_W-1:0] bank,
  output logic [ROW_W-1:0]  row,
  output logic [COL_W-1:0]  col
);
  localparam int TX_W = X_W - TILE_W_LOG;
  localparam int TY_W = Y_W - TILE_H_LOG;

  logic [TX_W-1:0] tile_x;
  logic [TY_W-1:0] tile_y;

  assign tile_x = x[X_W-1:TILE_W_LOG];
  assign tile_y = y[Y_W-1:TILE_H_LOG];

  always_comb begin
    col  = pix_col(y[TILE_H_LOG-1:0], x[TILE_W_LOG-1:0]);
    bank = tile_bank(tile_x[0], tile_y[0]);
    row  = tile_row(16'(tile_x), 16'(tile_y), 16'(HALF_TX));
  end
endmodule

// File: rtl/tile_span_calc.sv
module tile_span_calc
  import sdram_tile_pkg::*;
#(
  parameter int X_W = 11,
  parameter int Y_W = 11,
  parameter int SZ_W = 7
) (
  input  logic [X_W-1:0]            rx,
  input  logic [Y_W-1:0]            ry,
  input  logic [SZ_W-1:0]           rw,
  input  logic [SZ_W-1:0]           rh,
  output logic [X_W-TILE_W_LOG-1:0] tx_first,
  output logic [X_W-TILE_W_LOG-1:0] tx_last,
  output logic [Y_W-TILE_H_LOG-1:0] ty_first,
  output logic [Y_W-TILE_H_LOG-1:0] ty_last,
  output logic                      cross_x,
  output logic                      cross_y
);
  logic [X_W-1:0] x_end;
  logic [Y_W-1:0] y_end;

  // Last covered pixel on each axis (inclusive).
  assign x_end = rx + X_W'(rw) - X_W'(1);
  assign y_end = ry + Y_W'(rh) - Y_W'(1);

  assign tx_first = rx[X_W-1:TILE_W_LOG];
  assign tx_last  = x_end[X_W-1:TILE_W_LOG];
  assign ty_first = ry[Y_W-1:TILE_H_LOG];
  assign ty_last  = y_end[Y_W-1:TILE_H_LOG];

  assign cross_x = (tx_first != tx_last);
  assign cross_y = (ty_first != ty_last);
endmodule

// File: rtl/span_pack.sv
module span_pack
  import sdram_tile_pkg::*;
#(
  parameter int TX_W = 5,
  parameter int TY_W = 6,
  parameter int HALF_TX = 15
) (
  input  logic [TX_W-1:0]         tx_first,
  input  logic [TX_W-1:0]         tx_last,
  input  logic [TY_W-1:0]         ty_first,
  input  logic [TY_W-1:0]         ty_last,
  input  logic                    cross_x,
  input  logic                    cross_y,
  output logic [CNT_W-1:0]        count,
  output logic [NSLOT*BANK_W-1:0] banks,
  output logic [NSLOT*ROW_W-1:0]  rows
);
  assign count = span_count(cross_x, cross_y);

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    localparam logic [1:0] IDX = 2'(g);
    logic            sel_x;
    logic            sel_y;
    logic            used;
    logic [TX_W-1:0] stx;
    logic [TY_W-1:0] sty;

    // Horizontal crossing owns the low index bit; otherwise a vertical one does.
    assign sel_x = IDX[0] & cross_x;
    assign sel_y = cross_x ? IDX[1] : IDX[0];
    assign used  = (CNT_W'(g) < count);
    assign stx   = sel_x ? tx_last : tx_first;
    assign sty   = sel_y ? ty_last : ty_first;

    always_comb begin
      banks[g*BANK_W +: BANK_W] = used ? tile_bank(stx[0], sty[0]) : '0;
      rows[g*ROW_W +: ROW_W]    = used ? tile_row(16'(stx), 16'(sty), 16'(HALF_TX)) : '0;
    end
  end
endmodule

// File: rtl/sdram_tile_mapper.sv
module sdram_tile_mapper
  import sdram_tile_pkg::*;
#(
  parameter int FRAME_W = 1920,
  parameter int FRAME_H = 1088,
  parameter int SZ_W = 7,
  parameter int X_W = $clog2(FRAME_W),
  parameter int Y_W = $clog2(FRAME_H)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pt_valid,
  input  logic [X_W-1:0]          pt_x,
  input  logic [Y_W-1:0]          pt_y,
  output logic                    pt_out_valid,
  output logic [BANK_W-1:0]       pt_bank,
  output logic [ROW_W-1:0]        pt_row,
  output logic [COL_W-1:0]        pt_col,
  input  logic                    rq_valid,
  input  logic [X_W-1:0]          rq_x,
  input  logic [Y_W-1:0]          rq_y,
  input  logic [SZ_W-1:0]         rq_w,
  input  logic [SZ_W-1:0]         rq_h,
  output logic                    rs_valid,
  output logic [CNT_W-1:0]        rs_count,
  output logic [NSLOT*BANK_W-1:0] rs_bank,
  output logic [NSLOT*ROW_W-1:0]  rs_row
);
  localparam int TILES_X = FRAME_W / (1 << TILE_W_LOG);
  localparam int HALF_TX = (TILES_X + 1) / 2;
  localparam int TX_W = X_W - TILE_W_LOG;
  localparam int TY_W = Y_W - TILE_H_LOG;

  // Named internal events, visible to the bound checker.
  logic [BANK_W-1:0]       pt_bank_nx;
  logic [ROW_W-1:0]        pt_row_nx;
  logic [COL_W-1:0]        pt_col_nx;
  logic [TX_W-1:0]         span_tx_first;
  logic [TX_W-1:0]         span_tx_last;
  logic [TY_W-1:0]         span_ty_first;
  logic [TY_W-1:0]         span_ty_last;
  logic                    span_cross_x;
  logic                    span_cross_y;
  logic [CNT_W-1:0]        span_count_nx;
  logic [NSLOT*BANK_W-1:0] span_banks_nx;
  logic [NSLOT*ROW_W-1:0]  span_rows_nx;

  pix_addr_decode #(.X_W(X_W), .Y_W(Y_W), .HALF_TX(HALF_TX)) u_decode (
    .x(pt_x), .y(pt_y), .bank(pt_bank_nx), .row(pt_row_nx), .col(pt_col_nx)
  );

  tile_span_calc #(.X_W(X_W), .Y_W(Y_W), .SZ_W(SZ_W)) u_span (
    .rx(rq_x), .ry(rq_y), .rw(rq_w), .rh(rq_h),
    .tx_first(span_tx_first), .tx_last(span_tx_last),
    .ty_first(span_ty_first), .ty_last(span_ty_last),
    .cross_x(span_cross_x), .cross_y(span_cross_y)
  );

  span_pack #(.TX_W(TX_W), .TY_W(TY_W), .HALF_TX(HALF_TX)) u_pack (
    .tx_first(span_tx_first), .tx_last(span_tx_last),
    .ty_first(span_ty_first), .ty_last(span_ty_last),
    .cross_x(span_cross_x), .cross_y(span_cross_y),
    .count(span_count_nx), .banks(span_banks_nx), .rows(span_rows_nx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pt_out_valid <= 1'b0;
      pt_bank      <= '0;
      pt_row       <= '0;
      pt_col       <= '0;
    end else begin
      pt_out_valid <= pt_valid;
      if (pt_valid) begin
        pt_bank <= pt_bank_nx;
        pt_row  <= pt_row_nx;
        pt_col  <= pt_col_nx;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_valid <= 1'b0;
      rs_count <= '0;
      rs_bank  <= '0;
      rs_row   <= '0;
    end else begin
      rs_valid <= rq_valid;
      if (rq_valid) begin
        rs_count <= span_count_nx;
        rs_bank  <= span_banks_nx;
        rs_row   <= span_rows_nx;
      end
    end
  end
endmodule

// File: rtl/sdram_tile_mapper_chk.sv
module sdram_tile_mapper_chk
  import sdram_tile_pkg::*;
#(
  parameter int X_W = 11,
  parameter int Y_W = 11
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    pt_valid,
  input logic [X_W-1:0]          pt_x,
  input logic [Y_W-1:0]          pt_y,
  input logic                    pt_out_valid,
  input logic [BANK_W-1:0]       pt_bank,
  input logic [ROW_W-1:0]        pt_row,
  input logic [COL_W-1:0]        pt_col,
  input logic                    rq_valid,
  input logic [X_W-1:0]          rq_x,
  input logic [Y_W-1:0]          rq_y,
  input logic                    rs_valid,
  input logic [CNT_W-1:0]        rs_count,
  input logic [NSLOT*BANK_W-1:0] rs_bank,
  input logic [NSLOT*ROW_W-1:0]  rs_row
);
  logic [NSLOT-1:0] bank_seen;

  always_comb begin
    bank_seen = '0;
    for (int k = 0; k < NSLOT; k++)
      if (CNT_W'(k) < rs_count) bank_seen[rs_bank[k*BANK_W +: BANK_W]] = 1'b1;
  end

  // R1: point valid latency
  p_pt_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pt_valid |=> pt_out_valid);
  p_pt_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !pt_valid |=> !pt_out_valid);
  // R3: bank follows tile parity of the coordinate
  p_pt_bank_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pt_valid |=> (pt_bank == {$past(pt_y[TILE_H_LOG]), $past(pt_x[TILE_W_LOG])}));
  // R8: point address holds while idle
  p_pt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pt_valid |=> ($stable(pt_bank) && $stable(pt_row) && $stable(pt_col)));
  // R7: span valid latency and hold
  p_rs_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid |=> rs_valid);
  p_rs_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rq_valid |=> (!rs_valid && $stable(rs_count) && $stable(rs_bank) && $stable(rs_row)));
  // R5: legal count and distinct banks
  p_rs_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |-> (rs_count == 3'd1 || rs_count == 3'd2 || rs_count == 3'd4));
  p_rs_distinct_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |-> ($countones(bank_seen) == 32'(rs_count)));
  // R6: slot 0 is the start tile, unused slots are zero
  p_rs_slot0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid |=> (rs_bank[1:0] == {$past(rq_y[TILE_H_LOG]), $past(rq_x[TILE_W_LOG])}));
  p_rs_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_count == 3'd1) |->
      (rs_bank[NSLOT*BANK_W-1:BANK_W] == '0 && rs_row[NSLOT*ROW_W-1:ROW_W] == '0));
endmodule

bind sdram_tile_mapper sdram_tile_mapper_chk #(.X_W(X_W), .Y_W(Y_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pt_valid(pt_valid), .pt_x(pt_x), .pt_y(pt_y),
  .pt_out_valid(pt_out_valid), .pt_bank(pt_bank), .pt_row(pt_row), .pt_col(pt_col),
  .rq_valid(rq_valid), .rq_x(rq_x), .rq_y(rq_y), .rs_valid(rs_valid),
  .rs_count(rs_count), .rs_bank(rs_bank), .rs_row(rs_row)
);

// File: tb/sdram_tile_mapper_tb.sv
module sdram_tile_mapper_tb;
  localparam int FW = 1920;
  localparam int FH = 1088;
  localparam int XW = 11;
  localparam int YW = 11;
  localparam int HTX = ((FW / 64) + 1) / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pt_valid = 1'b0;
  logic [XW-1:0] pt_x = '0;
  logic [YW-1:0] pt_y = '0;
  logic pt_out_valid;
  logic [1:0] pt_bank;
  logic [11:0] pt_row;
  logic [8:0] pt_col;
  logic rq_valid = 1'b0;
  logic [XW-1:0] rq_x = '0;
  logic [YW-1:0] rq_y = '0;
  logic [6:0] rq_w = 7'd1;
  logic [6:0] rq_h = 7'd1;
  logic rs_valid;
  logic [2:0] rs_count;
  logic [7:0] rs_bank;
  logic [47:0] rs_row;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  int unsigned seed_v = 32'd12345;

  always #5 clk = ~clk;

  sdram_tile_mapper #(.FRAME_W(FW), .FRAME_H(FH)) u_dut (.*);

  function automatic int exp_bank(int tx, int ty);
    return (ty % 2) * 2 + (tx % 2);
  endfunction
  function automatic int exp_row(int tx, int ty);
    return (ty / 2) * HTX + tx / 2;
  endfunction
  function automatic int exp_col(int x, int y);
    return (y % 32) * 16 + (x % 64) / 4;
  endfunction

  task automatic check(string req, longint got, longint exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  // Drive one point, then check after the registering edge.
  task automatic do_point(int x, int y);
    @(negedge clk);
    pt_valid = 1'b1; pt_x = XW'(x); pt_y = YW'(y);
    @(negedge clk);
    pt_valid = 1'b0;
    check("R1 point valid", pt_out_valid, 1);
    check("R2 column", pt_col, exp_col(x, y));
    check("R3 bank", pt_bank, exp_bank(x / 64, y / 32));
    check("R4 row", pt_row, exp_row(x / 64, y / 32));
  endtask

  task automatic do_rect(int x, int y, int w, int h);
    int tx0, tx1, ty0, ty1, n;
    int sx[4];
    int sy[4];
    logic [7:0] eb;
    logic [47:0] er;
    tx0 = x / 64; tx1 = (x + w - 1) / 64;
    ty0 = y / 32; ty1 = (y + h - 1) / 32;
    n = 0;
    sx[0] = tx0; sy[0] = ty0; n = 1;
    if (tx1 != tx0) begin sx[n] = tx1; sy[n] = ty0; n++; end
    if (ty1 != ty0) begin
      sx[n] = tx0; sy[n] = ty1; n++;
      if (tx1 != tx0) begin sx[n] = tx1; sy[n] = ty1; n++; end
    end
    eb = '0; er = '0;
    for (int i = 0; i < n; i++) begin
      eb[i*2 +: 2] = 2'(exp_bank(sx[i], sy[i]));
      er[i*12 +: 12] = 12'(exp_row(sx[i], sy[i]));
    end
    @(negedge clk);
    rq_valid = 1'b1; rq_x = XW'(x); rq_y = YW'(y); rq_w = 7'(w); rq_h = 7'(h);
    @(negedge clk);
    rq_valid = 1'b0;
    check("R7 span valid", rs_valid, 1);
    check("R5 span count", rs_count, n);
    check("R6 span banks", rs_bank, eb);
    check("R6 span rows", rs_row, er);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [1:0] hb; logic [11:0] hr; logic [8:0] hc;
    logic [2:0] hn; logic [7:0] hbk; logic [47:0] hrw;
    void'($urandom(seed_v));
    repeat (3) @(negedge clk);
    check("R1 reset pt_out_valid", pt_out_valid, 0);
    check("R1 reset pt_row", pt_row, 0);
    check("R1 reset rs_valid", rs_valid, 0);
    check("R1 reset rs_bank", rs_bank, 0);
    rst_n = 1'b1;

    // Directed points: origin, tile edges, last pixel of the frame.
    do_point(0, 0);
    do_point(63, 31);
    do_point(64, 0);
    do_point(0, 32);
    do_point(127, 63);
    do_point(FW - 1, FH - 1);
    do_point(700, 500);

    // R8: point address holds while pt_valid is low and inputs change.
    hb = pt_bank; hr = pt_row; hc = pt_col;
    @(negedge clk);
    pt_x = 11'd5; pt_y = 11'd40;
    @(negedge clk);
    check("R8 hold valid low", pt_out_valid, 0);
    check("R8 hold bank", pt_bank, hb);
    check("R8 hold row", pt_row, hr);
    check("R8 hold col", pt_col, hc);

    // Directed rectangles: inside, edge-exact, one-pixel straddle, both edges.
    do_rect(0, 0, 64, 32);
    do_rect(8, 4, 21, 21);
    do_rect(63, 0, 1, 1);
    do_rect(63, 5, 2, 1);
    do_rect(10, 31, 4, 2);
    do_rect(60, 28, 8, 8);
    do_rect(FW - 21, FH - 21, 21, 21);
    do_rect(1900, 1060, 20, 28);

    // R7: span outputs hold while rq_valid is low.
    hn = rs_count; hbk = rs_bank; hrw = rs_row;
    @(negedge clk);
    rq_x = 11'd100; rq_y = 11'd3; rq_w = 7'd40;
    @(negedge clk);
    check("R7 hold valid low", rs_valid, 0);
    check("R7 hold count", rs_count, hn);
    check("R7 hold banks", rs_bank, hbk);
    check("R7 hold rows", rs_row, hrw);

    // Random points and rectangles.
    for (int k = 0; k < 200; k++) begin
      int x, y;
      x = int'($urandom_range(FW - 1, 0));
      y = int'($urandom_range(FH - 1, 0));
      do_point(x, y);
    end
    for (int k = 0; k < 300; k++) begin
      int w, h, x, y;
      if (k % 2 == 0) begin
        w = int'($urandom_range(21, 4)); h = int'($urandom_range(21, 4));
      end else begin
        w = int'($urandom_range(64, 1)); h = int'($urandom_range(32, 1));
      end
      x = int'($urandom_range(FW - w, 0));
      y = int'($urandom_range(FH - h, 0));
      do_rect(x, y, w, h);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule